// File: doc/BRIEF.md
# SPI Serial Memory Command Front-End

This block is the serial slave front end of an 8K x 8 serial nonvolatile memory, running in SPI mode 0. A host selects the device by pulling the chip-select input low. It then clocks in an 8-bit instruction, and for memory accesses a 16-bit address. The block decodes six instructions. A read streams bytes from a synchronous memory array through an auto-incrementing pointer. A status read returns the status byte supplied by a neighbouring block. Write enable, write disable, status write and array write are passed on to neighbouring blocks as one-cycle requests. Those blocks own the status contents, the protection decisions, the write buffer and the programming timer.

All serial pins are sampled by the system clock through a synchronizer, and the serial clock edges are detected internally. Each half period of the serial clock must therefore last at least four system clocks. A pause input suspends a sequence without losing its state. While paused, the output is released and the serial clock and data input have no effect. The serial output is presented as a data bit plus an output enable. An enable of 0 stands for high impedance.

Top module: `spi_mem_frontend`

## Requirements
- R1: Serial input is taken on the rising serial clock edge, most significant bit first. The output bit changes only on the falling edge, also most significant bit first. The output enable stays 0 while an instruction or address is being received.
- R2: While chip select is high, the output enable is 0 and any partial sequence is dropped. A sequence cut short before its data is complete issues no request.
- R3: Opcode 0x06 produces one `cmd_wren` pulse and opcode 0x04 produces one `cmd_wrdi` pulse. Each pulse appears after chip select rises, and only if the sequence ended on a byte boundary.
- R4: Opcode 0x03 is followed by a 16-bit address whose top three bits are ignored. Array bytes are then shifted out back to back, and the pointer advances by one after each byte. After 0x1FFF the pointer wraps to 0x0000.
- R5: Opcode 0x02 is followed by a 16-bit address whose top three bits are ignored. Each complete data byte is presented on `wd_valid`/`wd_addr`/`wd_data`. Between bytes the low 6 address bits count up and wrap inside their 64-byte page, while the upper bits hold. When chip select rises after at least one whole byte, on a byte boundary, a `wr_commit` pulse follows.
- R6: Opcode 0x01 takes the next byte as the new status value. That byte is delivered on `sr_wr_en`/`sr_wr_data` after chip select rises on a byte boundary.
- R7: Opcode 0x05 shifts out `status_i`, sampled again at the end of each output byte, for as long as clocks continue. It works even while `busy_i` is 1.
- R8: While `busy_i` is 1 when an opcode completes, every opcode other than 0x05 is ignored. No request is issued and the output enable stays 0.
- R9: An opcode outside the six listed is ignored. No request is issued, and the output enable stays 0 until chip select goes high.
- R10: Pulling the pause input low while the serial clock is low suspends the sequence. While suspended, the output enable is 0 and serial clock and data transitions are ignored. Releasing the pause while the serial clock is low resumes exactly where the sequence left off.
- R11: The requests `cmd_wren`, `cmd_wrdi`, `sr_wr_en` and `wr_commit` each last one cycle. At most one is active at a time, and only in the cycle after a chip-select rise is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data from the host |
| spi_hold_n | input | 1 | Active-low pause |
| spi_so | output | 1 | Serial data to the host, 0 when not driven |
| spi_so_oe | output | 1 | Output enable for `spi_so`; 0 means high impedance |
| busy_i | input | 1 | Internal write cycle in progress |
| status_i | input | 8 | Status byte from the status block |
| arr_rd_en | output | 1 | Array read request |
| arr_addr | output | 13 | Array read address |
| arr_rd_data | input | 8 | Array read data, valid one cycle after the request |
| cmd_wren | output | 1 | Set-write-enable request pulse |
| cmd_wrdi | output | 1 | Clear-write-enable request pulse |
| sr_wr_en | output | 1 | Status write request pulse |
| sr_wr_data | output | 8 | New status value |
| wd_valid | output | 1 | Write data byte strobe |
| wd_addr | output | 13 | Address of the write data byte |
| wd_data | output | 8 | Write data byte |
| wr_commit | output | 1 | Start-programming request pulse |

## Verification
Several reads come from a vector table. One of them starts two bytes below the top of the array, so a pointer that fails to wrap returns bytes from nonexistent addresses. Another sets the ignored top address bits, so a decoder that uses them reads the wrong location. A page write that crosses the page end checks that only the low six bits wrap; a full-width increment would carry into the page number. Other directed cases check the following. A busy period must block write enable and reads while status still reads. An unknown opcode, a cut-short write and a write enable followed by stray bits must issue no request. A pause in the middle of a byte, with the clock toggling, must leave the byte intact once it resumes; a design that still counted clock edges while paused would hand back a shifted byte.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

   localparam logic [7:0] OPC_WEN_SET  = 8'h06;
   localparam logic [7:0] OPC_WEN_CLR  = 8'h04;
   localparam logic [7:0] OPC_STAT_RD  = 8'h05;
   localparam logic [7:0] OPC_STAT_WR  = 8'h01;
   localparam logic [7:0] OPC_ARR_RD   = 8'h03;
   localparam logic [7:0] OPC_ARR_WR   = 8'h02;

   typedef enum logic [3:0] {
      ST_OPCODE,
      ST_ADDR,
      ST_RD_STREAM,
      ST_WR_STREAM,
      ST_STAT_OUT,
      ST_STAT_IN,
      ST_STAT_HELD,
      ST_WEN_HELD,
      ST_WDIS_HELD,
      ST_DISCARD
   } fe_state_t;

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
   parameter int          N       = 4,
   parameter int          STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] lvl,
   output logic [N-1:0] rise,
   output logic [N-1:0] fall
);

   logic [N-1:0] prev;

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
         else        chain <= {chain[STAGES-2:0], din[i]};
      end
      assign lvl[i] = chain[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= lvl;
   end

   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;

endmodule

// File: rtl/spi_mem_opdec.sv
module spi_mem_opdec
   import spi_mem_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] opc,
   input  logic              busy,
   output fe_state_t         nxt,
   output logic              is_rd
);

   always_comb begin
      nxt   = ST_DISCARD;
      is_rd = 1'b0;
      if (opc == OPC_STAT_RD) begin
         nxt = ST_STAT_OUT;
      end else if (!busy) begin
         case (opc)
            OPC_WEN_SET: nxt = ST_WEN_HELD;
            OPC_WEN_CLR: nxt = ST_WDIS_HELD;
            OPC_STAT_WR: nxt = ST_STAT_IN;
            OPC_ARR_RD:  begin nxt = ST_ADDR; is_rd = 1'b1; end
            OPC_ARR_WR:  nxt = ST_ADDR;
            default:     nxt = ST_DISCARD;
         endcase
      end
   end

endmodule

// File: rtl/spi_mem_txshift.sv
module spi_mem_txshift #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              arm,
   input  logic              shift,
   input  logic [DATA_W-1:0] data,
   output logic              bit_out,
   output logic              drive
);

   logic [DATA_W-1:0] sreg;
   logic              pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg  <= '0;
         pend  <= 1'b0;
         drive <= 1'b0;
      end else if (clear) begin
         pend  <= 1'b0;
         drive <= 1'b0;
      end else begin
         if (arm) pend <= 1'b1;
         if (shift) begin
            if (pend) begin
               sreg  <= data;
               pend  <= 1'b0;
               drive <= 1'b1;
            end else begin
               sreg <= {sreg[DATA_W-2:0], 1'b0};
            end
         end
      end
   end

   assign bit_out = sreg[DATA_W-1];

endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
   import spi_mem_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 13,
   parameter int ADDR_BYTES  = 2,
   parameter int PAGE_W      = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_si,
   input  logic              spi_hold_n,
   output logic              spi_so,
   output logic              spi_so_oe,
   input  logic              busy_i,
   input  logic [DATA_W-1:0] status_i,
   output logic              arr_rd_en,
   output logic [ADDR_W-1:0] arr_addr,
   input  logic [DATA_W-1:0] arr_rd_data,
   output logic              cmd_wren,
   output logic              cmd_wrdi,
   output logic              sr_wr_en,
   output logic [DATA_W-1:0] sr_wr_data,
   output logic              wd_valid,
   output logic [ADDR_W-1:0] wd_addr,
   output logic [DATA_W-1:0] wd_data,
   output logic              wr_commit
);

   localparam int ADDR_BITS = ADDR_BYTES * DATA_W;
   localparam int BIT_W     = $clog2(DATA_W);
   localparam int ABYTE_W   = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
   localparam int HI_W      = ADDR_BITS - DATA_W;
   localparam int I_SCK = 0, I_CS = 1, I_SI = 2, I_HOLD = 3;

   initial begin
      assert (DATA_W == 8) else $fatal(1, "DATA_W must be 8");
      assert (ADDR_BYTES >= 2) else $fatal(1, "ADDR_BYTES must be at least 2");
      assert (ADDR_W <= ADDR_BITS) else $fatal(1, "ADDR_W exceeds address field");
      assert (PAGE_W >= 1 && PAGE_W <= ADDR_W) else $fatal(1, "bad PAGE_W");
      assert (SYNC_STAGES >= 2) else $fatal(1, "SYNC_STAGES must be at least 2");
   end

   // pin synchronizers and edge detection
   logic [3:0] pin_lvl, pin_rise, pin_fall;
   logic       edge_unused;

   spi_mem_sync #(.N(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1010)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({spi_hold_n, spi_si, spi_cs_n, spi_sck}),
      .lvl  (pin_lvl),
      .rise (pin_rise),
      .fall (pin_fall)
   );
   assign edge_unused = ^{pin_rise[I_HOLD], pin_rise[I_SI], pin_fall[I_HOLD:I_CS]};

   logic cs_lvl, cs_rise, si_lvl;
   assign cs_lvl  = pin_lvl[I_CS];
   assign cs_rise = pin_rise[I_CS];
   assign si_lvl  = pin_lvl[I_SI];

   // pause: pin level only taken while the serial clock is low
   logic paused;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              paused <= 1'b0;
      else if (!pin_lvl[I_SCK]) paused <= !pin_lvl[I_HOLD];
   end

   logic sck_up, sck_dn;
   assign sck_up = pin_rise[I_SCK] & ~paused & ~cs_lvl;
   assign sck_dn = pin_fall[I_SCK] & ~paused & ~cs_lvl;

   // sequence state
   fe_state_t          state;
   logic [BIT_W-1:0]   bitcnt;
   logic [DATA_W-2:0]  shin;
   logic [ABYTE_W-1:0] abyte;
   logic [HI_W-1:0]    addr_sh;
   logic [ADDR_W-1:0]  ptr;
   logic [DATA_W-1:0]  rdbyte;
   logic               rd_op, rd_wait, have_data, arm;

   logic [DATA_W-1:0]    byte_in;
   logic                 byte_done;
   logic [ADDR_BITS-1:0] addr_full;
   assign byte_in   = {shin, si_lvl};
   assign byte_done = sck_up && (bitcnt == BIT_W'(DATA_W - 1));
   assign addr_full = {addr_sh, byte_in};

   fe_state_t dec_nxt;
   logic      dec_rd;
   spi_mem_opdec #(.DATA_W(DATA_W)) u_dec (
      .opc  (byte_in),
      .busy (busy_i),
      .nxt  (dec_nxt),
      .is_rd(dec_rd)
   );

   // next address variants: page-local wrap for writes, whole-array wrap for reads
   logic [ADDR_W-1:0] ptr_page_nxt, ptr_lin_nxt;
   assign ptr_lin_nxt = ptr + 1'b1;
   if (PAGE_W < ADDR_W) begin : g_page
      assign ptr_page_nxt = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
   end else begin : g_flat
      assign ptr_page_nxt = ptr_lin_nxt;
   end

   logic addr_unused;
   if (ADDR_BITS > ADDR_W) begin : g_addr_drop
      assign addr_unused = ^addr_full[ADDR_BITS-1:ADDR_W];
   end else begin : g_addr_full
      assign addr_unused = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_OPCODE;
         bitcnt     <= '0;
         shin       <= '0;
         abyte      <= '0;
         addr_sh    <= '0;
         ptr        <= '0;
         rdbyte     <= '0;
         rd_op      <= 1'b0;
         rd_wait    <= 1'b0;
         have_data  <= 1'b0;
         arm        <= 1'b0;
         arr_rd_en  <= 1'b0;
         arr_addr   <= '0;
         cmd_wren   <= 1'b0;
         cmd_wrdi   <= 1'b0;
         sr_wr_en   <= 1'b0;
         sr_wr_data <= '0;
         wd_valid   <= 1'b0;
         wd_addr    <= '0;
         wd_data    <= '0;
         wr_commit  <= 1'b0;
      end else begin
         cmd_wren  <= 1'b0;
         cmd_wrdi  <= 1'b0;
         sr_wr_en  <= 1'b0;
         wr_commit <= 1'b0;
         wd_valid  <= 1'b0;
         arr_rd_en <= 1'b0;
         arm       <= 1'b0;
         rd_wait   <= arr_rd_en;
         if (rd_wait) rdbyte <= arr_rd_data;

         if (cs_rise && bitcnt == '0) begin
            case (state)
               ST_WEN_HELD:  cmd_wren <= 1'b1;
               ST_WDIS_HELD: cmd_wrdi <= 1'b1;
               ST_STAT_HELD: sr_wr_en <= 1'b1;
               ST_WR_STREAM: wr_commit <= have_data;
               default: ;
            endcase
         end

         if (cs_lvl) begin
            state     <= ST_OPCODE;
            bitcnt    <= '0;
            abyte     <= '0;
            have_data <= 1'b0;
         end else if (sck_up) begin
            shin   <= byte_in[DATA_W-2:0];
            bitcnt <= bitcnt + 1'b1;
            if (byte_done) begin
               case (state)
                  ST_OPCODE: begin
                     state <= dec_nxt;
                     rd_op <= dec_rd;
                     if (dec_nxt == ST_STAT_OUT) begin
                        rdbyte <= status_i;
                        arm    <= 1'b1;
                     end
                  end
                  ST_STAT_OUT: begin
                     rdbyte <= status_i;
                     arm    <= 1'b1;
                  end
                  ST_ADDR: begin
                     addr_sh <= addr_full[HI_W-1:0];
                     abyte   <= abyte + 1'b1;
                     if (abyte == ABYTE_W'(ADDR_BYTES - 1)) begin
                        ptr <= addr_full[ADDR_W-1:0];
                        if (rd_op) begin
                           state     <= ST_RD_STREAM;
                           arr_rd_en <= 1'b1;
                           arr_addr  <= addr_full[ADDR_W-1:0];
                           arm       <= 1'b1;
                        end else begin
                           state <= ST_WR_STREAM;
                        end
                     end
                  end
                  ST_RD_STREAM: begin
                     ptr       <= ptr_lin_nxt;
                     arr_rd_en <= 1'b1;
                     arr_addr  <= ptr_lin_nxt;
                     arm       <= 1'b1;
                  end
                  ST_WR_STREAM: begin
                     wd_valid  <= 1'b1;
                     wd_addr   <= ptr;
                     wd_data   <= byte_in;
                     ptr       <= ptr_page_nxt;
                     have_data <= 1'b1;
                  end
                  ST_STAT_IN: begin
                     sr_wr_data <= byte_in;
                     state      <= ST_STAT_HELD;
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   // output path
   logic tx_bit, tx_drive;
   spi_mem_txshift #(.DATA_W(DATA_W)) u_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (cs_lvl),
      .arm    (arm),
      .shift  (sck_dn),
      .data   (rdbyte),
      .bit_out(tx_bit),
      .drive  (tx_drive)
   );

   assign spi_so_oe = tx_drive & ~paused;
   assign spi_so    = spi_so_oe & tx_bit;

endmodule

// File: rtl/spi_mem_frontend_chk.sv
module spi_mem_frontend_chk
   import spi_mem_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int BIT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_lvl,
   input logic              cs_rise,
   input logic              paused,
   input logic [BIT_W-1:0]  bitcnt,
   input fe_state_t         state,
   input logic              byte_done,
   input logic [DATA_W-1:0] byte_in,
   input logic              busy_i,
   input logic              so_oe,
   input logic              cmd_wren,
   input logic              cmd_wrdi,
   input logic              sr_wr_en,
   input logic              wr_commit
);

   p_hiz_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_lvl |=> !so_oe);

   p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(paused) && !$past(cs_lvl)) |-> $stable(bitcnt));

   p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && state == ST_OPCODE && busy_i && byte_in != OPC_STAT_RD)
      |=> state == ST_DISCARD);

   p_discard_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DISCARD) |-> !so_oe);

   p_req_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_wren, cmd_wrdi, sr_wr_en, wr_commit}));

   p_req_after_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wren || cmd_wrdi || sr_wr_en || wr_commit) |-> $past(cs_rise));

endmodule

bind spi_mem_frontend spi_mem_frontend_chk #(.DATA_W(DATA_W), .BIT_W(BIT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_lvl   (cs_lvl),
   .cs_rise  (cs_rise),
   .paused   (paused),
   .bitcnt   (bitcnt),
   .state    (state),
   .byte_done(byte_done),
   .byte_in  (byte_in),
   .busy_i   (busy_i),
   .so_oe    (spi_so_oe),
   .cmd_wren (cmd_wren),
   .cmd_wrdi (cmd_wrdi),
   .sr_wr_en (sr_wr_en),
   .wr_commit(wr_commit)
);

// File: tb/spi_mem_frontend_test.sv
module spi_mem_frontend_test;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
   logic        so, so_oe;
   logic        busy = 1'b0;
   logic [7:0]  status = 8'h00;
   logic        arr_rd_en;
   logic [12:0] arr_addr;
   logic [7:0]  arr_rd_data = 8'h00;
   logic        cmd_wren, cmd_wrdi, sr_wr_en, wd_valid, wr_commit;
   logic [7:0]  sr_wr_data, wd_data;
   logic [12:0] wd_addr;

   int checks = 0, errors = 0;
   int n_wren = 0, n_wrdi = 0, n_srw = 0, n_commit = 0, n_wd = 0;
   logic [12:0] wd_log_a [8];
   logic [7:0]  wd_log_d [8];
   logic [7:0]  last_sr = 8'h00;
   bit          finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   spi_mem_frontend uut (
      .clk(clk), .rst_n(rst_n),
      .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si), .spi_hold_n(hold_n),
      .spi_so(so), .spi_so_oe(so_oe),
      .busy_i(busy), .status_i(status),
      .arr_rd_en(arr_rd_en), .arr_addr(arr_addr), .arr_rd_data(arr_rd_data),
      .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
      .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
      .wd_valid(wd_valid), .wd_addr(wd_addr), .wd_data(wd_data),
      .wr_commit(wr_commit)
   );

   function automatic logic [7:0] arr_val(input logic [12:0] a);
      return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
   endfunction

   // array model with one cycle of read latency
   always @(posedge clk) if (arr_rd_en) arr_rd_data <= arr_val(arr_addr);

   always @(posedge clk) begin
      if (cmd_wren)  n_wren++;
      if (cmd_wrdi)  n_wrdi++;
      if (wr_commit) n_commit++;
      if (sr_wr_en) begin n_srw++; last_sr = sr_wr_data; end
      if (wd_valid) begin
         if (n_wd < 8) begin wd_log_a[n_wd] = wd_addr; wd_log_d[n_wd] = wd_data; end
         n_wd++;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sck_bit(input logic b, output logic so_b, output logic oe_b);
      si = b;
      wait_clk(HALF);
      so_b = so;
      oe_b = so_oe;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe_any);
      logic sb, ob;
      oe_any = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         sck_bit(tx[i], sb, ob);
         rx[i] = sb;
         oe_any |= ob;
      end
   endtask

   task automatic cs_lo();
      cs_n = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic cs_hi();
      wait_clk(HALF);
      cs_n = 1'b1;
      wait_clk(4 * HALF);
   endtask

   // read vectors: {address sent, effective start address}
   localparam logic [28:0] RD_VEC [4] = '{
      {16'h0000, 13'h0000},
      {16'h1234, 13'h1234},
      {16'hE005, 13'h0005},
      {16'h1FFE, 13'h1FFE}
   };

   initial begin
      logic [7:0] rx;
      logic       oe_any, sb, ob;
      int         base;

      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      check("R2 reset output enable", {31'd0, so_oe}, 32'd0);
      check("R11 reset no requests", n_wren + n_wrdi + n_srw + n_commit + n_wd, 0);

      // table-driven sequential reads
      foreach (RD_VEC[v]) begin
         cs_lo();
         xfer(8'h03, rx, oe_any);
         xfer(RD_VEC[v][28:21], rx, ob);
         oe_any |= ob;
         xfer(RD_VEC[v][20:13], rx, ob);
         oe_any |= ob;
         check("R1 no drive during opcode/address", {31'd0, oe_any}, 32'd0);
         for (int k = 0; k < 3; k++) begin
            logic [12:0] ea;
            ea = RD_VEC[v][12:0] + 13'(k);
            xfer(8'h00, rx, oe_any);
            check("R4 read stream byte", {24'd0, rx}, {24'd0, arr_val(ea)});
            check("R1 output driven in data phase", {31'd0, oe_any}, 32'd1);
         end
         cs_hi();
         check("R2 output released after CS high", {31'd0, so_oe}, 32'd0);
      end

      // status read while busy, value refreshed per byte
      busy = 1'b1;
      status = 8'hA5;
      cs_lo();
      xfer(8'h05, rx, oe_any);
      status = 8'h3C;
      xfer(8'h00, rx, oe_any);
      check("R7 status first byte", {24'd0, rx}, 32'h0000_00A5);
      xfer(8'h00, rx, oe_any);
      check("R7 status refreshed byte", {24'd0, rx}, 32'h0000_003C);
      cs_hi();

      // busy blocks other instructions
      base = n_wren;
      cs_lo();
      xfer(8'h06, rx, oe_any);
      cs_hi();
      check("R8 write enable ignored while busy", n_wren, base);
      cs_lo();
      xfer(8'h03, rx, oe_any);
      xfer(8'h00, rx, oe_any);
      xfer(8'h10, rx, oe_any);
      xfer(8'h00, rx, oe_any);
      check("R8 read ignored while busy", {31'd0, oe_any}, 32'd0);
      cs_hi();
      busy = 1'b0;

      // write enable / disable
      base = n_wren;
      cs_lo();
      xfer(8'h06, rx, oe_any);
      cs_hi();
      check("R3 write enable request", n_wren, base + 1);
      base = n_wrdi;
      cs_lo();
      xfer(8'h04, rx, oe_any);
      cs_hi();
      check("R3 write disable request", n_wrdi, base + 1);
      base = n_wren;
      cs_lo();
      xfer(8'h06, rx, oe_any);
      for (int i = 0; i < 3; i++) sck_bit(1'b0, sb, ob);
      cs_hi();
      check("R3 misaligned end gives no request", n_wren, base);

      // unknown opcode
      base = n_wren + n_wrdi + n_srw + n_commit + n_wd;
      cs_lo();
      xfer(8'hFF, rx, oe_any);
      xfer(8'h00, rx, oe_any);
      check("R9 unknown opcode keeps output released", {31'd0, oe_any}, 32'd0);
      cs_hi();
      check("R9 unknown opcode issues nothing", n_wren + n_wrdi + n_srw + n_commit + n_wd, base);

      // page write crossing the page end, top address bits ignored
      base = n_commit;
      n_wd = 0;
      cs_lo();
      xfer(8'h02, rx, oe_any);
      xfer(8'hE7, rx, oe_any);
      xfer(8'hFE, rx, oe_any);
      xfer(8'h11, rx, oe_any);
      xfer(8'h22, rx, oe_any);
      xfer(8'h33, rx, oe_any);
      cs_hi();
      check("R5 write byte count", n_wd, 3);
      check("R5 write addr 0", {19'd0, wd_log_a[0]}, 32'h07FE);
      check("R5 write addr 1", {19'd0, wd_log_a[1]}, 32'h07FF);
      check("R5 write addr page wrap", {19'd0, wd_log_a[2]}, 32'h07C0);
      check("R5 write data", {8'd0, wd_log_d[0], wd_log_d[1], wd_log_d[2]}, 32'h0011_2233);
      check("R5 commit request", n_commit, base + 1);

      // status write
      base = n_srw;
      cs_lo();
      xfer(8'h01, rx, oe_any);
      xfer(8'h8C, rx, oe_any);
      cs_hi();
      check("R6 status write request", n_srw, base + 1);
      check("R6 status write value", {24'd0, last_sr}, 32'h0000_008C);

      // cut-short write
      base = n_commit;
      n_wd = 0;
      cs_lo();
      xfer(8'h02, rx, oe_any);
      xfer(8'h00, rx, oe_any);
      cs_hi();
      check("R2 aborted write issues no commit", n_commit, base);
      check("R2 aborted write issues no data", n_wd, 0);

      // pause in the middle of a read byte
      cs_lo();
      xfer(8'h03, rx, oe_any);
      xfer(8'h01, rx, oe_any);
      xfer(8'h00, rx, oe_any);
      for (int i = 7; i >= 5; i--) begin
         sck_bit(1'b0, sb, ob);
         rx[i] = sb;
      end
      hold_n = 1'b0;
      wait_clk(HALF);
      check("R10 output released while paused", {31'd0, so_oe}, 32'd0);
      for (int i = 0; i < 3; i++) begin
         si = 1'b1;
         sck = 1'b1;
         wait_clk(HALF);
         sck = 1'b0;
         wait_clk(HALF);
      end
      check("R10 output stays released", {31'd0, so_oe}, 32'd0);
      hold_n = 1'b1;
      wait_clk(HALF);
      for (int i = 4; i >= 0; i--) begin
         sck_bit(1'b0, sb, ob);
         rx[i] = sb;
      end
      check("R10 byte intact across pause", {24'd0, rx}, {24'd0, arr_val(13'h0100)});
      xfer(8'h00, rx, oe_any);
      check("R10 stream continues after pause", {24'd0, rx}, {24'd0, arr_val(13'h0101)});
      cs_hi();

      check("R11 total enable requests", n_wren, 1);
      check("R11 total disable requests", n_wrdi, 1);

      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule